// File: doc/BRIEF.md
# Microprogrammed Instruction Fetch Sequencer

This block is the micro-level controller for the fetch phase of a simple stored-program CPU. A micro-address register selects a word in a small control ROM. Each cycle the selected 10-bit control word is loaded into a micro-buffer register. The bits of that register drive the datapath strobes directly. These strobes cover:

- bus source selects;
- the ALU operation;
- the destination load enables;
- the memory read request.

No major or minor state registers exist. The phase of the fetch is fully carried by the micro-address.

The stored sequence has three words. The first places the program counter on the address register and starts a memory read. The second adds the constant one to the program counter. The third moves the memory buffer contents into the instruction register. The micro-address steps by one per clock and returns to zero after the last word of the sequence, so the fetch repeats continuously.

The sequence length is a parameter. Control ROM locations past the fetch words read as all zeros and issue no strobes.

Top module: `ufetch_seq`

## Requirements
- R1: While rst_ni is low, uaddr_o is 0 and all ten strobes are 0.
- R2: After reset is released, uaddr_o increments by one on every rising clock edge.
- R3: When uaddr_o equals SEQ_LEN-1, uaddr_o returns to 0 on the next rising edge.
- R4: The control word is read as the 10-bit vector {pc_to_b1_o, one_to_b2_o, mbr_to_b2_o, b3_to_mar_o, b3_to_pc_o, b3_to_ir_o, alu_add_o, alu_pass1_o, alu_pass2_o, mem_read_o}, with bit 9 first. One edge after uaddr_o is 0, this word is 0x245 (PC on bus 1, pass bus 1, load MAR, read).
- R5: One edge after uaddr_o is 1, the word is 0x328 (PC on bus 1, constant one on bus 2, add, load PC).
- R6: One edge after uaddr_o is 2, the word is 0x092 (MBR on bus 2, pass bus 2, load IR).
- R7: Strobes lag the micro-address by one cycle. For micro-addresses 3 and above, which are reachable only when SEQ_LEN > 3, the word issued one edge later is 0x000.
- R8: In every issued word, at most one bus-2 source, at most one ALU operation and at most one bus-3 destination are active.
- R9: Asserting rst_ni asynchronously in mid-sequence forces uaddr_o and all strobes to 0 without waiting for a clock edge. The first word issued after release is 0x245.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; each rising edge starts a new microoperation |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_to_b1_o | output | 1 | Drive program counter onto bus 1 |
| one_to_b2_o | output | 1 | Drive constant one onto bus 2 |
| mbr_to_b2_o | output | 1 | Drive memory buffer onto bus 2 |
| b3_to_mar_o | output | 1 | Load memory address register from bus 3 |
| b3_to_pc_o | output | 1 | Load program counter from bus 3 |
| b3_to_ir_o | output | 1 | Load instruction register from bus 3 |
| alu_add_o | output | 1 | ALU adds bus 1 and bus 2 onto bus 3 |
| alu_pass1_o | output | 1 | ALU copies bus 1 onto bus 3 |
| alu_pass2_o | output | 1 | ALU copies bus 2 onto bus 3 |
| mem_read_o | output | 1 | Start a memory read into the memory buffer |
| uaddr_o | output | UADDR_W | Current micro-address |

## Verification
The clocked properties assume the following about the inputs:

- rst_ni is low from time zero.
- rst_ni rises away from a clock edge, so the first edge after release sees the reset values.
- SEQ_LEN is no larger than the micro-address space.

The stimulus meets these assumptions in three ways. It holds reset through the first edges, it changes rst_ni only on falling clock edges or mid-phase, and it instantiates a second copy with SEQ_LEN = 5, which fits a 4-bit address, to reach the zero words.

// File: rtl/ufetch_seq_pkg.sv
package ufetch_seq_pkg;

  localparam int UWORD_W = 10;

  // field order is fixed: bit 9 .. bit 0
  typedef struct packed {
    logic pc_to_b1;
    logic one_to_b2;
    logic mbr_to_b2;
    logic b3_to_mar;
    logic b3_to_pc;
    logic b3_to_ir;
    logic alu_add;
    logic alu_pass1;
    logic alu_pass2;
    logic mem_read;
  } uword_t;

  localparam logic [UWORD_W-1:0] UW_ADDR_RD = 10'h245;
  localparam logic [UWORD_W-1:0] UW_PC_INC  = 10'h328;
  localparam logic [UWORD_W-1:0] UW_IR_LD   = 10'h092;
  localparam logic [UWORD_W-1:0] UW_NOP     = 10'h000;

endpackage

// File: rtl/ufetch_seq_uaddr.sv
module ufetch_seq_uaddr #(
  parameter int UADDR_W = 4,
  parameter int SEQ_LEN = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [UADDR_W-1:0] uaddr_o
);
  localparam logic [UADDR_W-1:0] LAST = UADDR_W'(SEQ_LEN - 1);

  logic [UADDR_W-1:0] uaddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              uaddr_q <= '0;
    else if (uaddr_q == LAST) uaddr_q <= '0;
    else                      uaddr_q <= uaddr_q + UADDR_W'(1);
  end

  assign uaddr_o = uaddr_q;
endmodule

// File: rtl/ufetch_seq_crom.sv
module ufetch_seq_crom
  import ufetch_seq_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic [UADDR_W-1:0] addr_i,
  output logic [UWORD_W-1:0] word_o
);
  always_comb begin
    case (int'(addr_i))
      0:       word_o = UW_ADDR_RD;
      1:       word_o = UW_PC_INC;
      2:       word_o = UW_IR_LD;
      default: word_o = UW_NOP;
    endcase
  end
endmodule

// File: rtl/ufetch_seq_umbr.sv
module ufetch_seq_umbr
  import ufetch_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [UWORD_W-1:0] word_i,
  output uword_t             word_o
);
  uword_t word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= uword_t'(word_i);
  end

  assign word_o = word_q;
endmodule

// File: rtl/ufetch_seq.sv
module ufetch_seq
  import ufetch_seq_pkg::*;
#(
  parameter int UADDR_W = 4,
  parameter int SEQ_LEN = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic               pc_to_b1_o,
  output logic               one_to_b2_o,
  output logic               mbr_to_b2_o,
  output logic               b3_to_mar_o,
  output logic               b3_to_pc_o,
  output logic               b3_to_ir_o,
  output logic               alu_add_o,
  output logic               alu_pass1_o,
  output logic               alu_pass2_o,
  output logic               mem_read_o,
  output logic [UADDR_W-1:0] uaddr_o
);
  logic [UADDR_W-1:0] uaddr;
  logic [UWORD_W-1:0] rom_word;
  uword_t             umbr;

  ufetch_seq_uaddr #(.UADDR_W(UADDR_W), .SEQ_LEN(SEQ_LEN)) u_uaddr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .uaddr_o(uaddr)
  );

  ufetch_seq_crom #(.UADDR_W(UADDR_W)) u_crom (
    .addr_i(uaddr),
    .word_o(rom_word)
  );

  ufetch_seq_umbr u_umbr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .word_i(rom_word),
    .word_o(umbr)
  );

  assign pc_to_b1_o  = umbr.pc_to_b1;
  assign one_to_b2_o = umbr.one_to_b2;
  assign mbr_to_b2_o = umbr.mbr_to_b2;
  assign b3_to_mar_o = umbr.b3_to_mar;
  assign b3_to_pc_o  = umbr.b3_to_pc;
  assign b3_to_ir_o  = umbr.b3_to_ir;
  assign alu_add_o   = umbr.alu_add;
  assign alu_pass1_o = umbr.alu_pass1;
  assign alu_pass2_o = umbr.alu_pass2;
  assign mem_read_o  = umbr.mem_read;
  assign uaddr_o     = uaddr;
endmodule

// File: rtl/ufetch_seq_chk.sv
module ufetch_seq_chk #(
  parameter int UADDR_W = 4,
  parameter int SEQ_LEN = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [9:0]         word_i,
  input logic [UADDR_W-1:0] uaddr_i
);
  localparam logic [UADDR_W-1:0] LAST = UADDR_W'(SEQ_LEN - 1);

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (uaddr_i == '0 && word_i == '0));

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_i != LAST) |=> (uaddr_i == $past(uaddr_i) + UADDR_W'(1)));

  // R3
  addr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_i == LAST) |=> (uaddr_i == '0));

  // R4
  word0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_i == UADDR_W'(0)) |=> (word_i == 10'h245));

  // R5
  word1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_i == UADDR_W'(1)) |=> (word_i == 10'h328));

  // R6
  word2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_i == UADDR_W'(2)) |=> (word_i == 10'h092));

  // R7
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_i > UADDR_W'(2)) |=> (word_i == 10'h000));

  // R8
  bus_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(word_i[8:7]) && $onehot0(word_i[6:4]) && $onehot0(word_i[3:1]));
endmodule

bind ufetch_seq ufetch_seq_chk #(.UADDR_W(UADDR_W), .SEQ_LEN(SEQ_LEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .word_i ({pc_to_b1_o, one_to_b2_o, mbr_to_b2_o, b3_to_mar_o, b3_to_pc_o,
            b3_to_ir_o, alu_add_o, alu_pass1_o, alu_pass2_o, mem_read_o}),
  .uaddr_i(uaddr_o)
);

// File: tb/ufetch_seq_bench.sv
module ufetch_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0] ua, ua_l;
  logic s0, s1, s2, s3, s4, s5, s6, s7, s8, s9;
  logic l0, l1, l2, l3, l4, l5, l6, l7, l8, l9;
  wire [9:0] w   = {s0, s1, s2, s3, s4, s5, s6, s7, s8, s9};
  wire [9:0] w_l = {l0, l1, l2, l3, l4, l5, l6, l7, l8, l9};

  ufetch_seq u_ufetch_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .pc_to_b1_o(s0), .one_to_b2_o(s1), .mbr_to_b2_o(s2), .b3_to_mar_o(s3),
    .b3_to_pc_o(s4), .b3_to_ir_o(s5), .alu_add_o(s6), .alu_pass1_o(s7),
    .alu_pass2_o(s8), .mem_read_o(s9), .uaddr_o(ua)
  );

  ufetch_seq #(.UADDR_W(4), .SEQ_LEN(5)) u_ufetch_seq_long (
    .clk_i(clk), .rst_ni(rst_n),
    .pc_to_b1_o(l0), .one_to_b2_o(l1), .mbr_to_b2_o(l2), .b3_to_mar_o(l3),
    .b3_to_pc_o(l4), .b3_to_ir_o(l5), .alu_add_o(l6), .alu_pass1_o(l7),
    .alu_pass2_o(l8), .mem_read_o(l9), .uaddr_o(ua_l)
  );

  // {expected uaddr, expected word} after edge k = 1..6
  localparam logic [13:0] VEC [6] = '{
    {4'd1, 10'h245}, {4'd2, 10'h328}, {4'd0, 10'h092},
    {4'd1, 10'h245}, {4'd2, 10'h328}, {4'd0, 10'h092}
  };
  localparam logic [13:0] VEC_L [6] = '{
    {4'd1, 10'h245}, {4'd2, 10'h328}, {4'd3, 10'h092},
    {4'd4, 10'h000}, {4'd0, 10'h000}, {4'd1, 10'h245}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic excl_ok(input logic [9:0] x);
    return ($countones(x[8:7]) <= 1) && ($countones(x[6:4]) <= 1)
        && ($countones(x[3:1]) <= 1);
  endfunction

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // reset held across two edges
    @(negedge clk);
    @(negedge clk);
    chk("R1 uaddr", 16'(ua), 16'd0);
    chk("R1 word", 16'(w), 16'h000);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 on both copies
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R2/R3 uaddr", 16'(ua), 16'(VEC[k][13:10]));
      chk("R4/R5/R6 word", 16'(w), 16'(VEC[k][9:0]));
      chk("R2/R3 long uaddr", 16'(ua_l), 16'(VEC_L[k][13:10]));
      chk("R7 long word", 16'(w_l), 16'(VEC_L[k][9:0]));
      chk("R8 exclusivity", 16'(excl_ok(w)), 16'd1);
    end

    // R4 individual strobe bits of the first word
    @(negedge clk);
    chk("R4 pc_to_b1/mar/pass1/read", 16'({s0, s3, s7, s9}), 16'hF);
    chk("R4 others quiet", 16'({s1, s2, s4, s5, s6, s8}), 16'h0);

    // R9: asynchronous reset in mid-sequence, observed before any edge
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R9 uaddr", 16'(ua), 16'd0);
    chk("R9 word", 16'(w), 16'h000);
    chk("R9 long uaddr", 16'(ua_l), 16'd0);
    @(negedge clk);
    chk("R1 held uaddr", 16'(ua), 16'd0);
    chk("R1 held word", 16'(w), 16'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 restart word", 16'(w), 16'h245);
    chk("R9 restart uaddr", 16'(ua), 16'd1);
    @(negedge clk);
    chk("R5 after restart", 16'(w), 16'h328);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule